// File: doc/BRIEF.md
# Lockstep Stimulus Playback and Response Capture Engine

This block is the pattern engine of a test station for a front-end readout card. A bank of stimulus memories, one per 16-bit channel, is swept by one shared address counter. Each clock, every channel memory and a trigger memory are read at the same address. The words appear together on a wide stimulus bus, and a trigger pulse follows bit 0 of the trigger word. Channels are grouped by source: there are `NSRC` sources of `CPS` channels each. During the same sweep, response words from `NLINK` incoming links are written into record memories. Each link word is 17 bits: 16 data bits plus one handshake bit.

A small register interface sets up a run. Software writes the first address and the word count, then writes the control register with the go bit set. The run lasts exactly that many clocks. Addresses wrap modulo the memory depth, and a count equal to the full depth is legal. A busy flag covers the sweep and a done flag marks its end. The stimulus output has no back-pressure: it is valid/ready-free and paced by the clock only. The response input is a valid/ready stream. Ready is high only while a run is active with capture enabled. Valid may be held high at any time, and a word is taken only on a cycle where both are high. A simple preload write port and a record read port give access to the memory arrays.

Top module: `stim_sweep_engine`

## Requirements
- R1: After reset, `stim_valid`, `trig_out` and `resp_ready` are 0, and every register reads 0. This includes busy (status bit 0) and done (status bit 1).
- R2: Register map, using `bus_addr`:
  - 0: first address (AW bits).
  - 1: word count (AW+1 bits).
  - 2: control. Bit 0 is go, which is write-only and reads 0. Bit 1 is capture enable.
  - 3: status. Bit 0 is busy, bit 1 is done.
  Written fields read back unchanged.
- R3: A go write with a nonzero count is accepted at clock edge E0. At edges E1..En (n = count), `stim_data[c*DW +: DW]` presents channel c's word at address (first + k) mod 2^AW, for k = 0..n-1. `stim_valid` is high for exactly those n cycles.
- R4: `trig_out` equals bit 0 of the trigger-memory word at the same address as the stimulus word on the same cycle. It is 0 whenever `stim_valid` is 0.
- R5: Busy reads 1 from E0 until edge En, where it falls and done rises. Done is cleared by the next accepted go.
- R6: A go write while busy is ignored: the sweep continues unchanged.
- R7: A go with count 0 sets done at E0, leaves busy at 0 and presents no stimulus word.
- R8: The address wraps from 2^AW-1 to 0, and a count of 2^AW sweeps every address exactly once.
- R9: `resp_ready` = busy AND capture enable. On each cycle with `resp_valid` and `resp_ready` high, every link's 17-bit word is written into its record memory at the record address. That address restarts at 0 on each accepted go and advances by one per accepted word. When ready is low, no word is written, even if valid is high.
- R10: `rec_rd_data` returns the record word of link `rec_rd_sel` at `rec_rd_addr`, one clock after both are presented.
- R11: When `pre_wr_en` is high, `pre_wdata` is written at `pre_addr` into the memory chosen by `pre_sel`. Values 0..NCH-1 select a stimulus channel; value NCH selects the trigger memory, which keeps bit 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | AW+1 | Register write data |
| bus_rdata | output | AW+1 | Register read data (combinational) |
| pre_wr_en | input | 1 | Preload write strobe |
| pre_sel | input | clog2(NCH+1) | Preload memory select |
| pre_addr | input | AW | Preload address |
| pre_wdata | input | DW | Preload data |
| stim_valid | output | 1 | Stimulus word valid |
| stim_data | output | NCH*DW | All channel words, channel c at bits c*DW |
| trig_out | output | 1 | Trigger pulse to the card |
| resp_valid | input | 1 | Response words present on all links |
| resp_ready | output | 1 | Response words accepted this cycle |
| resp_data | input | NLINK*(DW+1) | Link l at bits l*(DW+1); MSB is the handshake bit |
| rec_rd_sel | input | max(1,clog2(NLINK)) | Record memory select |
| rec_rd_addr | input | AW | Record read address |
| rec_rd_data | output | DW+1 | Record read data |

## Verification
The bench builds the engine with AW=4, NSRC=2, CPS=2, NLINK=2 and DW=16. A 16-word memory depth brings several behaviours within a few dozen cycles: address wrap, a full-depth sweep (count 16) and full overwrites of the record memories. Two sources of two channels, plus two links, are enough to catch channel or link swaps in the bus packing and in the record select.

// File: rtl/stim_sweep_pkg.sv
package stim_sweep_pkg;

  typedef enum logic [1:0] {
    REG_FIRST  = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_CAP_BIT  = 1;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;

endpackage

// File: rtl/sync_word_ram.sv
module sync_word_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sweep_regs.sv
module sweep_regs
  import stim_sweep_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [AW:0]   wdata,
  output logic [AW:0]   rdata,
  input  logic          busy,
  input  logic          done,
  output logic [AW-1:0] first_addr,
  output logic [AW:0]   word_count,
  output logic          cap_en,
  output logic          go
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_addr <= '0;
      word_count <= '0;
      cap_en     <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        REG_FIRST: first_addr <= wdata[AW-1:0];
        REG_COUNT: word_count <= wdata;
        REG_CTRL:  cap_en     <= wdata[CTRL_CAP_BIT];
        default: ;
      endcase
    end
  end

  assign go = wr_en && (sel == REG_CTRL) && wdata[CTRL_GO_BIT];

  always_comb begin
    rdata = '0;
    case (sel)
      REG_FIRST:  rdata[AW-1:0] = first_addr;
      REG_COUNT:  rdata = word_count;
      REG_CTRL:   rdata[CTRL_CAP_BIT] = cap_en;
      REG_STATUS: begin
        rdata[STAT_BUSY_BIT] = busy;
        rdata[STAT_DONE_BIT] = done;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sweep_sequencer.sv
module sweep_sequencer #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] first_addr,
  input  logic [AW:0]   word_count,
  input  logic          cap_en,
  input  logic          resp_valid,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] rd_addr,
  output logic          stim_valid,
  output logic          resp_ready,
  output logic          rec_we,
  output logic [AW-1:0] rec_addr
);
  logic [AW:0] remain;

  assign resp_ready = busy & cap_en;
  assign rec_we     = resp_valid & resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      rd_addr    <= '0;
      remain     <= '0;
      rec_addr   <= '0;
      stim_valid <= 1'b0;
    end else begin
      stim_valid <= busy;
      if (busy) begin
        rd_addr <= rd_addr + 1'b1;
        remain  <= remain - 1'b1;
        if (remain == {{AW{1'b0}}, 1'b1}) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        if (rec_we) rec_addr <= rec_addr + 1'b1;
      end else if (go) begin
        rd_addr  <= first_addr;
        rec_addr <= '0;
        if (word_count == '0) begin
          done <= 1'b1;
        end else begin
          done   <= 1'b0;
          busy   <= 1'b1;
          remain <= word_count;
        end
      end
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R5
  AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain != '0)); // R3
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) || $past(go))); // R5
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (go && busy && remain > 1) |=> (busy && remain == $past(remain) - 1'b1)); // R6
  AST_VALID_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> $fell(stim_valid)); // R3
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && word_count == '0) |=> (done && !busy)); // R7
endmodule

// File: rtl/stim_sweep_engine.sv
module stim_sweep_engine #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int NSRC  = 5,
  parameter int CPS   = 5,
  parameter int NLINK = 6,
  localparam int NCH  = NSRC * CPS,
  localparam int SW   = $clog2(NCH + 1),
  localparam int LSW  = (NLINK > 1) ? $clog2(NLINK) : 1,
  localparam int LKW  = DW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [1:0]        bus_addr,
  input  logic [AW:0]       bus_wdata,
  output logic [AW:0]       bus_rdata,
  input  logic              pre_wr_en,
  input  logic [SW-1:0]     pre_sel,
  input  logic [AW-1:0]     pre_addr,
  input  logic [DW-1:0]     pre_wdata,
  output logic              stim_valid,
  output logic [NCH*DW-1:0] stim_data,
  output logic              trig_out,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [NLINK*LKW-1:0] resp_data,
  input  logic [LSW-1:0]    rec_rd_sel,
  input  logic [AW-1:0]     rec_rd_addr,
  output logic [LKW-1:0]    rec_rd_data
);
  logic          busy, done, cap_en, go, rec_we;
  logic [AW-1:0] first_addr, rd_addr, rec_addr;
  logic [AW:0]   word_count;

  sweep_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
    .first_addr(first_addr), .word_count(word_count), .cap_en(cap_en), .go(go)
  );

  sweep_sequencer #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .first_addr(first_addr),
    .word_count(word_count), .cap_en(cap_en), .resp_valid(resp_valid),
    .busy(busy), .done(done), .rd_addr(rd_addr), .stim_valid(stim_valid),
    .resp_ready(resp_ready), .rec_we(rec_we), .rec_addr(rec_addr)
  );

  logic [DW-1:0] chan_q [NCH];
  logic          trig_q;

  for (genvar c = 0; c < NCH; c++) begin : g_stim
    sync_word_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk(clk), .we(pre_wr_en && (pre_sel == SW'(c))), .waddr(pre_addr),
      .wdata(pre_wdata), .re(busy), .raddr(rd_addr), .rdata(chan_q[c])
    );
    assign stim_data[c*DW +: DW] = chan_q[c];
  end

  sync_word_ram #(.AW(AW), .DW(1)) u_trig_ram (
    .clk(clk), .we(pre_wr_en && (pre_sel == SW'(NCH))), .waddr(pre_addr),
    .wdata(pre_wdata[0]), .re(busy), .raddr(rd_addr), .rdata(trig_q)
  );

  assign trig_out = stim_valid & trig_q;

  logic [LKW-1:0] rec_q [NLINK];
  logic [LSW-1:0] sel_q;

  for (genvar l = 0; l < NLINK; l++) begin : g_rec
    sync_word_ram #(.AW(AW), .DW(LKW)) u_ram (
      .clk(clk), .we(rec_we), .waddr(rec_addr), .wdata(resp_data[l*LKW +: LKW]),
      .re(1'b1), .raddr(rec_rd_addr), .rdata(rec_q[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= rec_rd_sel;
  end

  assign rec_rd_data = (32'(sel_q) < NLINK) ? rec_q[sel_q] : '0;
endmodule

// File: tb/stim_sweep_engine_test.sv
module stim_sweep_engine_test;
  localparam int AW = 4, DW = 16, NSRC = 2, CPS = 2, NLINK = 2;
  localparam int NCH = NSRC * CPS, DEPTH = 1 << AW, LKW = DW + 1;
  localparam int SW = $clog2(NCH + 1);

  // columns: first address, count, capture enable, cycle of a go poke (-1 none)
  localparam int NRUN = 5;
  localparam int RUNS [NRUN][4] = '{
    '{3, 5, 1, 2},
    '{14, 4, 1, -1},
    '{7, 16, 0, -1},
    '{0, 16, 1, 5},
    '{9, 1, 1, -1}
  };

  logic clk = 0, rst_n = 0;
  logic bus_wr_en = 0;
  logic [1:0] bus_addr = 0;
  logic [AW:0] bus_wdata = 0, bus_rdata;
  logic pre_wr_en = 0;
  logic [SW-1:0] pre_sel = 0;
  logic [AW-1:0] pre_addr = 0;
  logic [DW-1:0] pre_wdata = 0;
  logic stim_valid, trig_out, resp_ready;
  logic [NCH*DW-1:0] stim_data;
  logic resp_valid = 0;
  logic [NLINK*LKW-1:0] resp_data = 0;
  logic [0:0] rec_rd_sel = 0;
  logic [AW-1:0] rec_rd_addr = 0;
  logic [LKW-1:0] rec_rd_data;

  int n_chk = 0, n_bad = 0;
  logic [LKW-1:0] rec_model [NLINK][DEPTH];
  bit rec_known [NLINK][DEPTH];

  always #10 clk = ~clk;

  stim_sweep_engine #(.AW(AW), .DW(DW), .NSRC(NSRC), .CPS(CPS), .NLINK(NLINK)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pre_wr_en(pre_wr_en),
    .pre_sel(pre_sel), .pre_addr(pre_addr), .pre_wdata(pre_wdata),
    .stim_valid(stim_valid), .stim_data(stim_data), .trig_out(trig_out),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .rec_rd_sel(rec_rd_sel), .rec_rd_addr(rec_rd_addr), .rec_rd_data(rec_rd_data)
  );

  function automatic logic [DW-1:0] chan_word(int c, int a);
    return DW'(((c + 1) << 12) | (a << 4) | c);
  endfunction

  function automatic logic trig_bit(int a);
    return ((a % 3) == 0) ^ (a > 10);
  endfunction

  function automatic logic [LKW-1:0] link_word(int r, int l, int k);
    return {k[0], 16'h8000 ^ DW'(r << 8) ^ DW'(l << 4) ^ DW'(k)};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [AW:0] d);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic read_reg(logic [1:0] a, output logic [AW:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_run(int r);
    int s, n, c, p, cnt;
    logic [AW:0] st;
    logic [63:0] exp;
    s = RUNS[r][0]; n = RUNS[r][1]; c = RUNS[r][2]; p = RUNS[r][3];
    bus_write(2'd0, (AW+1)'(s));
    bus_write(2'd1, (AW+1)'(n));
    bus_write(2'd2, {3'b0, c[0], 1'b1});
    read_reg(2'd3, st);
    check(st[1:0] == 2'b01, "R5 busy set, done cleared at go", 64'(st), 64'h1);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      logic v;
      v = ((k + r) % 3) != 0;
      resp_valid = v;
      for (int l = 0; l < NLINK; l++) resp_data[l*LKW +: LKW] = link_word(r, l, k);
      if (k == p) begin
        bus_wr_en = 1; bus_addr = 2'd2; bus_wdata = {3'b0, c[0], 1'b1};
      end else begin
        bus_wr_en = 0;
      end
      check(resp_ready == c[0], "R9 ready follows capture enable", 64'(resp_ready), 64'(c));
      if (v && c[0]) begin
        for (int l = 0; l < NLINK; l++) begin
          rec_model[l][cnt] = link_word(r, l, k);
          rec_known[l][cnt] = 1;
        end
        cnt++;
      end
      @(negedge clk);
      bus_wr_en = 0;
      exp = 0;
      for (int ch = 0; ch < NCH; ch++) exp[ch*DW +: DW] = chan_word(ch, (s + k) % DEPTH);
      check(stim_valid == 1, "R3 valid during sweep", 64'(stim_valid), 64'h1);
      check(stim_data == exp[NCH*DW-1:0], (k == p + 1 && p >= 0) ? "R6 word after ignored go" :
            ((s + k) >= DEPTH ? "R8 wrapped word" : "R3 word"), 64'(stim_data), exp);
      check(trig_out == trig_bit((s + k) % DEPTH), "R4 trigger bit", 64'(trig_out),
            64'(trig_bit((s + k) % DEPTH)));
      read_reg(2'd3, st);
      check(st[0] == (k < n - 1), "R5 busy through last word", 64'(st[0]), 64'(k < n - 1));
    end
    resp_valid = 1;
    @(negedge clk);
    check(stim_valid == 0 && trig_out == 0, "R3 valid length exact", 64'({stim_valid, trig_out}), 64'h0);
    check(resp_ready == 0, "R9 ready low when idle", 64'(resp_ready), 64'h0);
    read_reg(2'd3, st);
    check(st[1:0] == 2'b10, "R5 done after run", 64'(st), 64'h2);
    resp_valid = 0;
    for (int l = 0; l < NLINK; l++)
      for (int i = 0; i < DEPTH; i++)
        if (rec_known[l][i]) begin
          rec_rd_sel = l[0]; rec_rd_addr = AW'(i);
          @(negedge clk);
          check(rec_rd_data == rec_model[l][i], "R10 R9 record word", 64'(rec_rd_data),
                64'(rec_model[l][i]));
        end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog expired: actual 20000 cycles expected fewer");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW:0] d;
    for (int l = 0; l < NLINK; l++)
      for (int i = 0; i < DEPTH; i++) rec_known[l][i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(stim_valid == 0 && trig_out == 0 && resp_ready == 0, "R1 outputs in reset", 64'({stim_valid, trig_out, resp_ready}), 64'h0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), d);
      check(d == 0, "R1 register after reset", 64'(d), 64'h0);
    end
    // R11: preload channels and trigger memory
    for (int sel = 0; sel <= NCH; sel++)
      for (int a = 0; a < DEPTH; a++) begin
        @(negedge clk);
        pre_wr_en = 1; pre_sel = SW'(sel); pre_addr = AW'(a);
        pre_wdata = (sel == NCH) ? (16'h5A00 | DW'(trig_bit(a))) : chan_word(sel, a);
      end
    @(negedge clk);
    pre_wr_en = 0;
    // R2: register readback
    bus_write(2'd0, 5'd9);
    read_reg(2'd0, d); check(d == 5'd9, "R2 first address", 64'(d), 64'd9);
    bus_write(2'd1, 5'd16);
    read_reg(2'd1, d); check(d == 5'd16, "R2 count", 64'(d), 64'd16);
    bus_write(2'd2, 5'b00010);
    read_reg(2'd2, d); check(d == 5'b00010, "R2 control", 64'(d), 64'h2);
    read_reg(2'd3, d); check(d == 0, "R2 status idle", 64'(d), 64'h0);
    // table of runs: R3 R4 R5 R6 R8 R9 R10 R11
    for (int r = 0; r < NRUN; r++) do_run(r);
    // R7: zero count
    bus_write(2'd1, 5'd0);
    bus_write(2'd2, 5'b00011);
    read_reg(2'd3, d);
    check(d[1:0] == 2'b10, "R7 zero count sets done only", 64'(d), 64'h2);
    check(stim_valid == 0, "R7 no word presented", 64'(stim_valid), 64'h0);
    @(negedge clk);
    check(stim_valid == 0 && resp_ready == 0, "R7 still idle", 64'({stim_valid, resp_ready}), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule